// File: doc/BRIEF.md
# Dual-Clock FIFO with Synchronized Status Flags

This block is a 64-entry, 36-bit first-in first-out buffer that links two unrelated clock domains. Port A writes and runs on its own clock. Port B reads and runs on a second clock. Each port has a four-signal access qualifier: an active-low select, a direction bit, a side-channel select and an enable. The FIFO is only touched when all four of these agree with that port's role. When the side-channel select is high the FIFO is left alone. No storage sits behind that select.

The write and read positions are binary counters. Each is converted to Gray code and crosses into the other domain through a two-stage synchronizer. The write domain computes an active-low full flag from its own position and the synchronized read position. The read domain computes an active-low almost-empty flag from its own position and the synchronized write position. It asserts that flag whenever the stored word count is at or below a threshold parameter. Port B presents data through an output register. That register holds the last word read until the next accepted read.

Top module: `xclk_fifo`

## Requirements
- R1: While `rst_n` is low, `a_full_n` is 1, `b_aempty_n` is 0 and `b_data` is 0. Both position counters restart at zero.
- R2: A word is stored on a rising `a_clk` edge only when `a_sel_n`=0, `a_dir`=1, `a_mbx`=0 and `a_en`=1. Every other combination of those four bits leaves the FIFO unchanged.
- R3: A word is taken on a rising `b_clk` edge only when `b_sel_n`=0, `b_dir`=0, `b_mbx`=0 and `b_en`=1 and the FIFO is not empty. Every other combination is ignored.
- R4: Words leave port B in the order they entered port A, with all 36 bits intact.
- R5: `b_data` changes only on a rising `b_clk` edge that takes a word. Otherwise it keeps the last word taken.
- R6: `a_full_n` goes to 0 on the `a_clk` edge that stores the 64th word. While it is 0, write attempts change no stored word.
- R7: A read attempt while the FIFO is empty leaves `b_data` unchanged.
- R8: When no write is in flight, `b_aempty_n` is 0 exactly when the stored count is at most `AE_LEVEL` (default 8). It updates on the `b_clk` edge of the read that reaches that count.
- R9: After a read frees space in a full FIFO, `a_full_n` returns to 1 after the two-stage synchronizer and the flag register. That takes no sooner than the second `a_clk` edge after the read, and within six `a_clk` cycles.
- R10: After a write lifts the count above `AE_LEVEL`, `b_aempty_n` rises no sooner than the second `b_clk` edge after the write, and within six `b_clk` cycles.
- R11: Each Gray-coded position changes by at most one bit per clock of its own domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| a_clk | input | 1 | Write-domain clock |
| a_sel_n | input | 1 | Port A select, active low |
| a_dir | input | 1 | Port A direction; 1 selects a write |
| a_mbx | input | 1 | Port A side-channel select; must be 0 to reach the FIFO |
| a_en | input | 1 | Port A enable, active high |
| a_data | input | DATA_W | Word to store |
| a_full_n | output | 1 | Full flag, active low, in the `a_clk` domain |
| b_clk | input | 1 | Read-domain clock |
| b_sel_n | input | 1 | Port B select, active low |
| b_dir | input | 1 | Port B direction; 0 selects a read |
| b_mbx | input | 1 | Port B side-channel select; must be 0 to reach the FIFO |
| b_en | input | 1 | Port B enable, active high |
| b_data | output | DATA_W | Registered output word |
| b_aempty_n | output | 1 | Almost-empty flag, active low, in the `b_clk` domain |

## Verification
Two functions can land on the same clock edge. The first pair is the read that takes a word and the almost-empty flag update: the flag is computed from the post-read position, so the read that brings the count down to the threshold must drop the flag on that very edge. The bench drains a full FIFO and checks the flag after every read. It expects the flag high after the read that leaves nine words and low after the read that leaves eight. The second pair is the 64th write and the full flag. The bench checks that `a_full_n` is already low at the sample point that follows the storing edge, and that a further write attempt does not replace any stored word.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;

    // Port qualifier: select low, direction matching the port's role,
    // side-channel select low, enable high.
    function automatic logic port_hit(
        input logic sel_n,
        input logic dir,
        input logic dir_want,
        input logic mbx,
        input logic en
    );
        return (!sel_n) && (dir == dir_want) && (!mbx) && en;
    endfunction

endpackage

// File: rtl/xclk_sync2.sv
module xclk_sync2 #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s1: '0, s2: '0};
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/xclk_wr_ctl.sv
module xclk_wr_ctl #(
    parameter int PTR_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic [PTR_W-1:0] rgray_sync,
    output logic [PTR_W-2:0] waddr,
    output logic [PTR_W-1:0] wgray,
    output logic             we,
    output logic             full_n
);
    localparam int DEPTH = 1 << (PTR_W - 1);

    typedef struct packed {
        logic [PTR_W-1:0] bin;
        logic [PTR_W-1:0] gray;
        logic             full_n;
    } wstate_t;

    wstate_t          st_d, st_q;
    logic [PTR_W-1:0] full_pat;
    logic [PTR_W-1:0] rsync_bin;

    always_comb begin
        for (int i = 0; i < PTR_W; i++) begin
            rsync_bin[i] = ^(rgray_sync >> i);
        end
    end

    always_comb begin
        we          = wr_req & st_q.full_n;
        st_d        = st_q;
        st_d.bin    = st_q.bin + PTR_W'(we);
        st_d.gray   = st_d.bin ^ (st_d.bin >> 1);
        full_pat    = {~rgray_sync[PTR_W-1 -: 2], rgray_sync[PTR_W-3:0]};
        st_d.full_n = (st_d.gray != full_pat);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{bin: '0, gray: '0, full_n: 1'b1};
        else        st_q <= st_d;
    end

    assign waddr  = st_q.bin[PTR_W-2:0];
    assign wgray  = st_q.gray;
    assign full_n = st_q.full_n;

    // R6: occupancy seen from the write side never exceeds the depth
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (PTR_W'(st_q.bin - rsync_bin) <= PTR_W'(DEPTH)));

    // R6: a request while full does not move the write position
    assert_hold_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !st_q.full_n) |=> (waddr == $past(waddr)));

    // R11: one bit of the crossing code per write clock
    assert_gray_step_wr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(st_q.gray ^ $past(st_q.gray)) <= 1));
endmodule

// File: rtl/xclk_rd_ctl.sv
module xclk_rd_ctl #(
    parameter int PTR_W    = 7,
    parameter int AE_LEVEL = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_req,
    input  logic [PTR_W-1:0] wgray_sync,
    output logic [PTR_W-2:0] raddr,
    output logic [PTR_W-1:0] rgray,
    output logic             re,
    output logic             aempty_n
);
    localparam int DEPTH = 1 << (PTR_W - 1);

    typedef struct packed {
        logic [PTR_W-1:0] bin;
        logic [PTR_W-1:0] gray;
        logic             aempty_n;
    } rstate_t;

    rstate_t          st_d, st_q;
    logic [PTR_W-1:0] wsync_bin;
    logic [PTR_W-1:0] level_d;
    logic             empty;

    always_comb begin
        for (int i = 0; i < PTR_W; i++) begin
            wsync_bin[i] = ^(wgray_sync >> i);
        end
    end

    always_comb begin
        empty         = (st_q.gray == wgray_sync);
        re            = rd_req & ~empty;
        st_d          = st_q;
        st_d.bin      = st_q.bin + PTR_W'(re);
        st_d.gray     = st_d.bin ^ (st_d.bin >> 1);
        level_d       = wsync_bin - st_d.bin;
        st_d.aempty_n = (int'(level_d) > AE_LEVEL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{bin: '0, gray: '0, aempty_n: 1'b0};
        else        st_q <= st_d;
    end

    assign raddr    = st_q.bin[PTR_W-2:0];
    assign rgray    = st_q.gray;
    assign aempty_n = st_q.aempty_n;

    // R8: an empty FIFO always shows almost-empty
    assert_empty_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !st_q.aempty_n);

    // R7: a request while empty does not move the read position
    assert_no_underrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && empty) |=> (raddr == $past(raddr)));

    // R4: level seen from the read side stays within the depth
    assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (PTR_W'(wsync_bin - st_q.bin) <= PTR_W'(DEPTH)));

    // R11: one bit of the crossing code per read clock
    assert_gray_step_rd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(st_q.gray ^ $past(st_q.gray)) <= 1));
endmodule

// File: rtl/xclk_store.sv
module xclk_store #(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 6
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_comb begin
        rdata_d = rdata_q;
        if (re) rdata_d = mem[raddr];
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

    // R5: output register holds unless a word is taken
    assert_hold_output_R5: assert property (@(posedge rclk) disable iff (!rst_n)
        !re |=> $stable(rdata_q));
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
    import xclk_fifo_pkg::*;
#(
    parameter int DATA_W   = 36,
    parameter int ADDR_W   = 6,
    parameter int AE_LEVEL = 8
) (
    input  logic              rst_n,
    input  logic              a_clk,
    input  logic              a_sel_n,
    input  logic              a_dir,
    input  logic              a_mbx,
    input  logic              a_en,
    input  logic [DATA_W-1:0] a_data,
    output logic              a_full_n,
    input  logic              b_clk,
    input  logic              b_sel_n,
    input  logic              b_dir,
    input  logic              b_mbx,
    input  logic              b_en,
    output logic [DATA_W-1:0] b_data,
    output logic              b_aempty_n
);
    localparam int PTR_W = ADDR_W + 1;

    logic              wr_req, rd_req, we, re;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [PTR_W-1:0]  wgray, rgray, wgray_sync, rgray_sync;

    assign wr_req = port_hit(a_sel_n, a_dir, 1'b1, a_mbx, a_en);
    assign rd_req = port_hit(b_sel_n, b_dir, 1'b0, b_mbx, b_en);

    xclk_wr_ctl #(.PTR_W(PTR_W)) u_wr (
        .clk(a_clk), .rst_n(rst_n), .wr_req(wr_req), .rgray_sync(rgray_sync),
        .waddr(waddr), .wgray(wgray), .we(we), .full_n(a_full_n)
    );

    xclk_rd_ctl #(.PTR_W(PTR_W), .AE_LEVEL(AE_LEVEL)) u_rd (
        .clk(b_clk), .rst_n(rst_n), .rd_req(rd_req), .wgray_sync(wgray_sync),
        .raddr(raddr), .rgray(rgray), .re(re), .aempty_n(b_aempty_n)
    );

    xclk_sync2 #(.W(PTR_W)) u_w2r (
        .clk(b_clk), .rst_n(rst_n), .din(wgray), .dout(wgray_sync)
    );

    xclk_sync2 #(.W(PTR_W)) u_r2w (
        .clk(a_clk), .rst_n(rst_n), .din(rgray), .dout(rgray_sync)
    );

    xclk_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .wclk(a_clk), .we(we), .waddr(waddr), .wdata(a_data),
        .rclk(b_clk), .rst_n(rst_n), .re(re), .raddr(raddr), .rdata(b_data)
    );
endmodule

// File: tb/xclk_fifo_tb.sv
module xclk_fifo_tb;
    localparam int A_PERIOD = 10;
    localparam int B_PERIOD = 14;
    localparam logic [3:0] WR_OK = 4'b0101;
    localparam logic [3:0] RD_OK = 4'b0001;
    localparam logic [3:0] IDLE  = 4'b1000;
    // {sel_n, dir, mbx, en, write accepted, read accepted}
    localparam logic [5:0] DEC_TBL [16] = '{
        6'b000000, 6'b000101, 6'b001000, 6'b001100,
        6'b010000, 6'b010110, 6'b011000, 6'b011100,
        6'b100000, 6'b100100, 6'b101000, 6'b101100,
        6'b110000, 6'b110100, 6'b111000, 6'b111100
    };

    logic        rst_n, a_clk, b_clk;
    logic        a_sel_n, a_dir, a_mbx, a_en;
    logic        b_sel_n, b_dir, b_mbx, b_en;
    logic [35:0] a_data, b_data;
    logic        a_full_n, b_aempty_n;
    int          n_chk, n_fail;

    xclk_fifo u_dut (
        .rst_n(rst_n), .a_clk(a_clk), .a_sel_n(a_sel_n), .a_dir(a_dir),
        .a_mbx(a_mbx), .a_en(a_en), .a_data(a_data), .a_full_n(a_full_n),
        .b_clk(b_clk), .b_sel_n(b_sel_n), .b_dir(b_dir), .b_mbx(b_mbx),
        .b_en(b_en), .b_data(b_data), .b_aempty_n(b_aempty_n)
    );

    initial a_clk = 1'b0;
    always #(A_PERIOD / 2) a_clk = ~a_clk;
    initial b_clk = 1'b0;
    always #(B_PERIOD / 2) b_clk = ~b_clk;

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_pulse(input logic [3:0] ctl, input logic [35:0] d);
        @(negedge a_clk);
        {a_sel_n, a_dir, a_mbx, a_en} = ctl;
        a_data = d;
        @(posedge a_clk);
        #1;
        {a_sel_n, a_dir, a_mbx, a_en} = IDLE;
    endtask

    task automatic rd_pulse(input logic [3:0] ctl);
        @(negedge b_clk);
        {b_sel_n, b_dir, b_mbx, b_en} = ctl;
        @(posedge b_clk);
        #1;
        {b_sel_n, b_dir, b_mbx, b_en} = IDLE;
    endtask

    task automatic settle();
        repeat (8) @(negedge b_clk);
        repeat (8) @(negedge a_clk);
    endtask

    initial begin
        #(A_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [35:0] last;
        int          nxt;
        int          seen;
        n_chk = 0;
        n_fail = 0;
        rst_n = 1'b0;
        {a_sel_n, a_dir, a_mbx, a_en} = IDLE;
        {b_sel_n, b_dir, b_mbx, b_en} = IDLE;
        a_data = '0;
        #(A_PERIOD * 3 + 2);
        check("R1 full_n in reset", {35'd0, a_full_n}, 36'd1);
        check("R1 aempty_n in reset", {35'd0, b_aempty_n}, 36'd0);
        check("R1 b_data in reset", b_data, 36'd0);
        @(negedge a_clk);
        rst_n = 1'b1;
        settle();

        // R2: walk every qualifier combination on the write port
        for (int i = 0; i < 16; i++) begin
            wr_pulse(DEC_TBL[i][5:2], 36'hA_0000 + 36'(i));
        end
        settle();
        check("R8 one word is almost empty", {35'd0, b_aempty_n}, 36'd0);
        rd_pulse(RD_OK);
        @(negedge b_clk);
        check("R2 only qualified write stored", b_data, 36'hA_0005);
        rd_pulse(RD_OK);
        @(negedge b_clk);
        check("R7 read on empty holds output", b_data, 36'hA_0005);

        // R3: walk every qualifier combination on the read port
        for (int k = 0; k < 16; k++) wr_pulse(WR_OK, 36'hB_0000 + 36'(k));
        settle();
        check("R8 sixteen words not almost empty", {35'd0, b_aempty_n}, 36'd1);
        last = 36'hA_0005;
        nxt  = 0;
        for (int i = 0; i < 16; i++) begin
            rd_pulse(DEC_TBL[i][5:2]);
            @(negedge b_clk);
            if (DEC_TBL[i][0]) begin
                last = 36'hB_0000 + 36'(nxt);
                nxt++;
            end
            check("R3 R5 read qualifier decode", b_data, last);
        end
        for (int k = nxt; k < 16; k++) begin
            rd_pulse(RD_OK);
            @(negedge b_clk);
            check("R4 order after decode walk", b_data, 36'hB_0000 + 36'(k));
        end
        rd_pulse(RD_OK);
        @(negedge b_clk);
        check("R7 empty after drain", b_data, 36'hB_000F);
        settle();

        // R6: fill to the brim
        for (int k = 0; k < 63; k++) wr_pulse(WR_OK, 36'hC_0000 + 36'(k));
        @(negedge a_clk);
        check("R6 not full at 63", {35'd0, a_full_n}, 36'd1);
        wr_pulse(WR_OK, 36'hC_0000 + 36'd63);
        @(negedge a_clk);
        check("R6 full on 64th write edge", {35'd0, a_full_n}, 36'd0);
        wr_pulse(WR_OK, 36'hD_EAD0);
        settle();
        check("R6 still full", {35'd0, a_full_n}, 36'd0);

        // R9: full flag recovery latency
        rd_pulse(RD_OK);
        @(negedge a_clk);
        check("R9 full held right after read", {35'd0, a_full_n}, 36'd0);
        seen = 0;
        for (int c = 0; c < 6; c++) begin
            @(negedge a_clk);
            if (a_full_n) seen = 1;
        end
        check("R9 full released within window", 36'(seen), 36'd1);
        check("R4 first word of fill", b_data, 36'hC_0000);

        // R4 R8: drain with the threshold crossing judged on every read
        for (int k = 2; k <= 64; k++) begin
            rd_pulse(RD_OK);
            @(negedge b_clk);
            check("R4 fill order", b_data, 36'hC_0000 + 36'(k - 1));
            check("R8 threshold crossing", {35'd0, b_aempty_n}, ((64 - k) > 8) ? 36'd1 : 36'd0);
        end
        rd_pulse(RD_OK);
        @(negedge b_clk);
        check("R6 write while full was dropped", b_data, 36'hC_003F);
        settle();

        // R8 R10: rising edge of the almost-empty flag
        for (int k = 0; k < 8; k++) wr_pulse(WR_OK, 36'hE_0000 + 36'(k));
        settle();
        check("R8 count at threshold", {35'd0, b_aempty_n}, 36'd0);
        wr_pulse(WR_OK, 36'hE_0008);
        @(negedge b_clk);
        check("R10 flag held right after write", {35'd0, b_aempty_n}, 36'd0);
        seen = 0;
        for (int c = 0; c < 6; c++) begin
            @(negedge b_clk);
            if (b_aempty_n) seen = 1;
        end
        check("R10 flag released within window", 36'(seen), 36'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule